// File: doc/BRIEF.md
# Key-Unlocked Flash Programming Controller

This block sits between a host register port and a flash array and decides when an erase or program cycle may run. The host picks an operation by writing a 16-bit control register. The top bit of that register is the cycle trigger. The trigger cannot be set until the host has written a two-word magic key into a separate key register. Once it is set, the selected operation's strobe stays high until the host clears the trigger again. The block never times the cycle itself; the host holds the trigger for however long the array needs, typically a couple of milliseconds.

The lower fifteen bits of the control register carry the operation code. It is decoded into one-hot strobes: six for erase operations and two for write operations. An unrecognised code still lets the trigger set, but it raises an error flag instead of a strobe. The host sees a busy level for the whole cycle. It also sees a single-cycle completion pulse when a valid cycle is closed.

Top module: `flash_prog_ctl`

## Requirements
- R1: After reset, the control register reads 0x0000, and busy, done, op_err and all strobes are low.
- R2: `reg_addr` = 0 selects the control register and `reg_addr` = 1 selects the key register. A read of the control register returns {trigger, op[14:0]}, and a read of the key register returns 0x0000. `rdata` is 0 when `reg_rd` is low.
- R3: A control write with bit 15 high sets the trigger only when the two accesses just before it were key writes of 0x0055 and then 0x00AA. Otherwise bit 15 is ignored, while bits 14:0 are still stored if the trigger was clear.
- R4: Inside the key sequence, any access other than a key write of 0x00AA directly after the 0x0055 cancels the sequence. This covers a repeated 0x0055, a control read or write, and a key read. The sequence must then be restarted.
- R5: The unlock is good for exactly one following register access. A new key sequence is needed before every later trigger set.
- R6: `busy` equals the trigger bit. Once set, the trigger stays set for any length of time until the host writes the control register with bit 15 low.
- R7: Clearing the trigger needs no key sequence.
- R8: While the trigger is set, writes to bits 14:0 of the control register are ignored.
- R9: Erase strobes go high from the cycle after the setting write until the cycle after the clearing write. The codes on bits 14:0 are: 0x407F bulk erase → erase_sel[0]; 0x404E boot+general+vectors+their config → erase_sel[1]; 0x406E general+config → erase_sel[2]; 0x4042 general without vectors → erase_sel[3]; 0x4072 all executive memory → erase_sel[4]; 0x4071 one 32-word row → erase_sel[5].
- R10: Write strobes follow the same timing as R9. The code 0x4001 (one 32-word row) drives write_sel[0], and 0x4008 (one configuration word) drives write_sel[1].
- R11: Any other code raises `op_err` while the trigger is set. In that case no strobe goes high and no done pulse follows.
- R12: `done` is high for exactly one cycle, in the cycle after the write that clears the trigger of a valid operation.
- R13: At most one bit of {write_sel, erase_sel} is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = control, 1 = key |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| busy | output | 1 | Trigger bit level |
| done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Unknown operation while triggered |
| erase_sel | output | 6 | One-hot erase strobes |
| write_sel | output | 2 | One-hot write strobes |

## Verification
Register writes take effect at the clock edge that samples them. So busy, op_err and the strobes are compared at the falling edge right after the write has been released. Read data is combinational and is sampled 1 ns after the read is driven. The done pulse is checked at that same first falling edge and is checked low again one cycle later. The bench sweeps every code from 0x4000 to 0x407F plus several outside codes. For each one it derives the expected strobe from the decode table, then runs a full unlock, set, hold and clear cycle. A separate series of broken key sequences confirms that busy stays low and shows which bits of the control register were stored.

// File: rtl/fpc_pkg.sv
// Shared constants and types for the flash programming controller.
// Assumes a 16-bit register port; the op table order fixes strobe indices.
package fpc_pkg;
    localparam int REG_W    = 16;
    localparam int TRIG_BIT = REG_W - 1;
    localparam int OP_W     = REG_W - 1;
    localparam int N_ERASE  = 6;
    localparam int N_WRITE  = 2;
    localparam int N_OPS    = N_ERASE + N_WRITE;

    localparam logic [REG_W-1:0] KEY_FIRST  = 16'h0055;
    localparam logic [REG_W-1:0] KEY_SECOND = 16'h00AA;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_KEY  = 1'b1;

    // Index i of this table drives strobe bit i (erase first, then write).
    localparam logic [N_OPS*REG_W-1:0] OP_TABLE = {
        16'h4008, 16'h4001,
        16'h4071, 16'h4072, 16'h4042, 16'h406E, 16'h404E, 16'h407F
    };

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_st_t;
endpackage

// File: rtl/fpc_unlock.sv
// Key sequence tracker. It arms after a key write of KEY_FIRST followed
// directly by KEY_SECOND. Any other access cancels a partial sequence, and
// the armed state lasts for exactly one following register access.
// Assumes reg_wr and reg_rd are single-cycle strobes.
module fpc_unlock
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] wdata,
    output logic             armed
);
    unlock_st_t st_q, st_d;
    logic key_wr, any_acc, got_first, got_second;

    assign key_wr     = reg_wr && (reg_addr == ADDR_KEY);
    assign any_acc    = reg_wr || reg_rd;
    assign got_first  = key_wr && (wdata == KEY_FIRST);
    assign got_second = key_wr && (wdata == KEY_SECOND);

    // Next-state selection for the key sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UL_IDLE:  if (got_first) st_d = UL_HALF;
            UL_HALF:  if (got_second) st_d = UL_ARMED;
                      else if (any_acc) st_d = UL_IDLE;
            UL_ARMED: if (got_first) st_d = UL_HALF;
                      else if (any_acc) st_d = UL_IDLE;
            default:  st_d = UL_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= UL_IDLE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == UL_ARMED);

    AST_ARM_AFTER_SECOND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(reg_wr && reg_addr == ADDR_KEY && wdata == KEY_SECOND)); // R3
    AST_ARM_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (reg_wr || reg_rd)) |=> !armed); // R5
endmodule

// File: rtl/fpc_opdecode.sv
// Compares the stored operation field against every entry of the op table
// and produces a one-hot hit vector plus a valid flag. Purely combinational.
module fpc_opdecode
    import fpc_pkg::*;
(
    input  logic [OP_W-1:0]  op_field,
    output logic [N_OPS-1:0] hit,
    output logic             valid
);
    for (genvar i = 0; i < N_OPS; i++) begin : g_cmp
        // One comparator per table entry.
        assign hit[i] = (op_field == OP_TABLE[i*REG_W +: OP_W]);
    end

    assign valid = |hit;
endmodule

// File: rtl/fpc_cycle.sv
// Control register and cycle sequencing. It stores the op field and the
// trigger, allows the trigger to be set only while armed, lets the host
// clear it at any time, freezes the op field while triggered, and pulses
// done when a valid cycle is closed. Assumes op_valid decodes op_q.
module fpc_cycle
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             armed,
    input  logic             op_valid,
    output logic             trig,
    output logic [OP_W-1:0]  op,
    output logic             done
);
    logic            trig_q, done_q;
    logic [OP_W-1:0] op_q;
    logic            closing;

    assign closing = ctrl_wr && trig_q && !wdata[TRIG_BIT];

    // Control register update: op field only while idle, trigger gated by key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            op_q   <= '0;
        end else if (ctrl_wr) begin
            if (!trig_q) begin
                op_q   <= wdata[OP_W-1:0];
                trig_q <= wdata[TRIG_BIT] && armed;
            end else begin
                trig_q <= wdata[TRIG_BIT];
            end
        end
    end

    // Completion pulse for a closed valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= closing && op_valid;
    end

    assign trig = trig_q;
    assign op   = op_q;
    assign done = done_q;

    AST_SET_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_q) |-> $past(armed && ctrl_wr)); // R3
    AST_NO_SELF_END: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && !(ctrl_wr && !wdata[TRIG_BIT])) |=> trig_q); // R6
    AST_OP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |=> $stable(op_q)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R12
endmodule

// File: rtl/flash_prog_ctl.sv
// Top of the key-unlocked flash programming controller. It routes register
// accesses to the key tracker and the control register, decodes the op field
// into erase and write strobes gated by the trigger, and drives read data.
// Assumes the host times each cycle by setting and clearing the trigger.
module flash_prog_ctl
    import fpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic               busy,
    output logic               done,
    output logic               op_err,
    output logic [N_ERASE-1:0] erase_sel,
    output logic [N_WRITE-1:0] write_sel
);
    logic             armed, trig, op_valid, ctrl_wr;
    logic [OP_W-1:0]  op;
    logic [N_OPS-1:0] hit, strobes;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    fpc_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .wdata(wdata), .armed(armed)
    );

    fpc_opdecode u_dec (.op_field(op), .hit(hit), .valid(op_valid));

    fpc_cycle u_cyc (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(wdata),
        .armed(armed), .op_valid(op_valid), .trig(trig), .op(op), .done(done)
    );

    // Strobes only while the trigger holds.
    assign strobes   = trig ? hit : '0;
    assign erase_sel = strobes[N_ERASE-1:0];
    assign write_sel = strobes[N_OPS-1:N_ERASE];
    assign busy      = trig;
    assign op_err    = trig && !op_valid;

    // Read mux: control register readable, key register reads zero.
    always_comb begin
        rdata = '0;
        if (reg_rd && reg_addr == ADDR_CTRL) rdata = {trig, op};
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({write_sel, erase_sel})); // R13
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> ({write_sel, erase_sel} == '0)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({write_sel, erase_sel} == '0 && !op_err)); // R6
endmodule

// File: tb/flash_prog_ctl_test.sv
module flash_prog_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy, done, op_err;
    logic [5:0]  erase_sel;
    logic [1:0]  write_sel;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_prog_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata), .busy(busy),
        .done(done), .op_err(op_err), .erase_sel(erase_sel), .write_sel(write_sel)
    );

    function automatic logic [7:0] exp_strobe(input logic [14:0] c);
        case (c)
            15'h407F: return 8'h01;
            15'h404E: return 8'h02;
            15'h406E: return 8'h04;
            15'h4042: return 8'h08;
            15'h4072: return 8'h10;
            15'h4071: return 8'h20;
            15'h4001: return 8'h40;
            15'h4008: return 8'h80;
            default:  return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 v = rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic unlock();
        wr(1'b1, 16'h0055);
        wr(1'b1, 16'h00AA);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(1'b0, v);
        chk("R1 ctrl", v, 16'h0000);
        chk("R1 outputs", {busy, done, op_err, write_sel, erase_sel}, 0);
        // R2 key reads zero
        wr(1'b0, 16'h0123);
        rd(1'b1, v);
        chk("R2 key read", v, 16'h0000);
        // R3 set without key ignored, op field stored
        wr(1'b0, 16'h8234);
        chk("R3 no key busy", busy, 0);
        rd(1'b0, v);
        chk("R3 op stored", v, 16'h0234);
        // R4 repeated first key cancels
        wr(1'b1, 16'h0055); wr(1'b1, 16'h0055); wr(1'b1, 16'h00AA);
        wr(1'b0, 16'hC07F);
        chk("R4 double first key", busy, 0);
        // R4 read between keys cancels
        wr(1'b1, 16'h0055); rd(1'b0, v); wr(1'b1, 16'h00AA);
        wr(1'b0, 16'hC07F);
        chk("R4 read between", busy, 0);
        // R4 control write between keys cancels
        wr(1'b1, 16'h0055); wr(1'b0, 16'h0001); wr(1'b1, 16'h00AA);
        wr(1'b0, 16'hC07F);
        chk("R4 write between", busy, 0);
        // R4 key read between keys cancels
        wr(1'b1, 16'h0055); rd(1'b1, v); wr(1'b1, 16'h00AA);
        wr(1'b0, 16'hC07F);
        chk("R4 key read between", busy, 0);
        // R5 access after unlock consumes it
        unlock(); rd(1'b1, v);
        wr(1'b0, 16'hC07F);
        chk("R5 consumed by read", busy, 0);
        // R6 long hold, R8 op frozen, R7 clear without key
        unlock(); wr(1'b0, 16'hC001);
        chk("R6 set", busy, 1);
        repeat (1000) @(negedge clk);
        chk("R6 held", busy, 1);
        chk("R10 held strobe", write_sel, 2'b01);
        wr(1'b0, 16'hC008);
        rd(1'b0, v);
        chk("R8 op frozen", v, 16'hC001);
        wr(1'b0, 16'h0000);
        chk("R7 cleared", busy, 0);
        chk("R12 done", done, 1);
        // R5 second cycle needs new key
        wr(1'b0, 16'hC001);
        chk("R5 no rekey", busy, 0);
        // R9 R10 R11 R12 R13 sweep
        for (int c = 0; c < 134; c++) begin
            logic [14:0] code;
            logic [7:0]  es;
            case (c)
                128: code = 15'h0000;
                129: code = 15'h7FFF;
                130: code = 15'h0071;
                131: code = 15'h607F;
                132: code = 15'h4171;
                133: code = 15'h2001;
                default: code = 15'h4000 + 15'(c);
            endcase
            es = exp_strobe(code);
            unlock();
            wr(1'b0, {1'b1, code});
            chk("R6 busy on set", busy, 1);
            chk("R9 R10 strobes", {write_sel, erase_sel}, es);
            chk("R13 onehot", $countones({write_sel, erase_sel}) <= 1, 1);
            chk("R11 err", op_err, es == 8'h00);
            repeat (3) @(negedge clk);
            chk("R9 strobes held", {write_sel, erase_sel}, es);
            rd(1'b0, v);
            chk("R2 readback busy", v, {1'b1, code});
            wr(1'b0, 16'h0000);
            chk("R12 done pulse", done, es != 8'h00);
            chk("R9 strobes off", {write_sel, erase_sel, op_err, busy}, 0);
            @(negedge clk);
            chk("R12 done single", done, 0);
            rd(1'b0, v);
            chk("R8 op after clear", v, {1'b0, code});
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule